// File: doc/BRIEF.md
# Calendar Clock with Timed Update Cycle

This block keeps the time of day and the calendar for a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It is reached through a byte-wide register port with a 64-byte address space. The low addresses hold the time fields, with three alarm bytes placed between them. Four control and status registers follow, and the rest of the space is general-purpose RAM.

A prescaler counts clock cycles and marks one calendar second every `SEC_CYCLES` cycles. An update-in-progress flag goes high a fixed `UIP_CYCLES` before the time advances. Outside that window the time fields do not change, so software that sees the flag low can read a consistent time.

A freeze bit in the mode register stops all counting so that software can load a new time. The data format (binary or BCD) and the hour format (12 or 24 hour) can be changed at any time. The time is stored in binary and converted at the port, so a format change alters only how the stored time is shown.

Top module: `rtc_calendar`

## Requirements
- R1: The address map is: seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9. The alarm bytes sit at 1, 3 and 5. Configuration is at 10, mode at 11, flags at 12 and status at 13. RAM occupies 14 through 63. The alarm and RAM bytes read back what was last written, and writing them leaves the time unchanged.
- R2: While the clock is not frozen, the time advances by one second once every `SEC_CYCLES` clock cycles. Seconds and minutes roll over from 59 to 0, hours from 23 to 0, day of week from 7 to 1, month from 12 to 1 and year from 99 to 0. Each rollover carries into the next field.
- R3: Day of month rolls over to 1 after day 30 in April, June, September and November, and after day 31 in the other long months. February ends at 29 when the year is divisible by 4, and at 28 otherwise.
- R4: Bit 7 of the configuration register (address 10) is the update-in-progress flag. It is high for exactly `UIP_CYCLES` cycles before each advance and falls in the cycle the time changes. While it is low, the time fields change only through writes.
- R5: Bit 7 of the mode register (address 11) freezes the clock. While it is set, no advance occurs and the update-in-progress flag reads 0. After it is cleared, the next advance comes `SEC_CYCLES` cycles later.
- R6: Bit 2 of the mode register selects the data format: 1 is binary, 0 is BCD with the tens digit in bits 7:4 and the units digit in bits 3:0. The format applies to reads and writes of the time fields. Alarm bytes are stored raw.
- R7: Bit 1 of the mode register selects the hour format: 1 is 24-hour, counting 0 to 23. In 12-hour mode the hours byte shows 12, 1, ..., 11, with bit 7 set for PM. A 12-hour write of 12 with bit 7 clear means midnight, and with bit 7 set means noon.
- R8: Changing the format bits re-presents the stored time immediately, without altering it.
- R9: The status register (address 13) reads 0x80 and the flags register (address 12) reads 0x00. Writes to either register, and writes to bit 7 of the configuration register, have no effect. Bits 6:0 of the configuration register and all 8 bits of the mode register are stored.
- R10: After reset the time is 00:00:00, day of week 1, 1 January, year 0. The configuration register is 0, the mode register is 0x02 (BCD, 24-hour, running) and the RAM holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the time base for the prescaler |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe, acts on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
Random start times are loaded under each of the four combinations of data format and hour format. Seconds, minutes and hours are biased toward their last value so that carry chains of every length occur. Each result is compared with a bench model one update later, which separates a correct carry from one that stops early or spills too far.

Directed start times exercise the year-end rollover, February in leap and non-leap years, a 30-day month, and the 11 to 12 crossings in 12-hour mode, where the AM/PM bit must flip at the right edge. With the clock frozen, format switches and 12-hour writes of midnight and noon show whether conversion happens at the port or corrupts the stored value. A long run of reads across the low window shows whether the time is stable there.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int A_SEC  = 0;
  localparam int A_ASEC = 1;
  localparam int A_MIN  = 2;
  localparam int A_AMIN = 3;
  localparam int A_HR   = 4;
  localparam int A_AHR  = 5;
  localparam int A_DOW  = 6;
  localparam int A_DOM  = 7;
  localparam int A_MON  = 8;
  localparam int A_YR   = 9;
  localparam int A_CFG  = 10;
  localparam int A_MODE = 11;
  localparam int A_FLAG = 12;
  localparam int A_STAT = 13;
  localparam int RAM_BASE = 14;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [3:0] mon;
    logic [6:0] yr;
  } rtc_time_t;

  typedef enum logic [2:0] {
    FLD_SEC, FLD_MIN, FLD_HR, FLD_DOW, FLD_DOM, FLD_MON, FLD_YR
  } rtc_field_e;

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 8'd10);
    ones = 4'(v % 8'd10);
    return {tens, ones};
  endfunction

  function automatic logic [7:0] fmt_out(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : bin_to_bcd({1'b0, v});
  endfunction

  // leap rule: year divisible by 4, only the low two bits matter
  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [1:0] yr_lo);
    case (mon)
      4'd2:                      return (yr_lo == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick.sv
module rtc_tick #(
  parameter int unsigned SEC_CYCLES = 400,
  parameter int unsigned UIP_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  output logic uip_o,
  output logic step_o
);
  localparam int unsigned CW = $clog2(SEC_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SEC_CYCLES - 1);
  localparam logic [CW-1:0] OPEN = CW'(SEC_CYCLES - UIP_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (halt_i || cnt_q == LAST)   cnt_q <= '0;
    else                                cnt_q <= cnt_q + CW'(1);
  end

  // busy window is the tail of the prescaler period
  assign uip_o  = !halt_i && (cnt_q >= OPEN);
  assign step_o = !halt_i && (cnt_q == LAST);
endmodule

// File: rtl/rtc_count.sv
module rtc_count
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       wr_i,
  input  rtc_field_e field_i,
  input  logic [6:0] wval_i,
  output rtc_time_t  time_o
);
  rtc_time_t time_q, adv, nxt;

  always_comb begin
    adv = time_q;
    if (time_q.sec >= 6'd59) begin
      adv.sec = '0;
      if (time_q.min >= 6'd59) begin
        adv.min = '0;
        if (time_q.hr >= 5'd23) begin
          adv.hr  = '0;
          adv.dow = (time_q.dow >= 3'd7) ? 3'd1 : time_q.dow + 3'd1;
          if (time_q.dom >= month_days(time_q.mon, time_q.yr[1:0])) begin
            adv.dom = 5'd1;
            if (time_q.mon >= 4'd12) begin
              adv.mon = 4'd1;
              adv.yr  = (time_q.yr >= 7'd99) ? 7'd0 : time_q.yr + 7'd1;
            end else begin
              adv.mon = time_q.mon + 4'd1;
            end
          end else begin
            adv.dom = time_q.dom + 5'd1;
          end
        end else begin
          adv.hr = time_q.hr + 5'd1;
        end
      end else begin
        adv.min = time_q.min + 6'd1;
      end
    end else begin
      adv.sec = time_q.sec + 6'd1;
    end
  end

  // a port write overrides the advanced value of its own field
  always_comb begin
    nxt = step_i ? adv : time_q;
    if (wr_i) begin
      case (field_i)
        FLD_SEC: nxt.sec = wval_i[5:0];
        FLD_MIN: nxt.min = wval_i[5:0];
        FLD_HR:  nxt.hr  = wval_i[4:0];
        FLD_DOW: nxt.dow = wval_i[2:0];
        FLD_DOM: nxt.dom = wval_i[4:0];
        FLD_MON: nxt.mon = wval_i[3:0];
        FLD_YR:  nxt.yr  = wval_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '{sec: '0, min: '0, hr: '0, dow: 3'd1, dom: 5'd1, mon: 4'd1, yr: '0};
    end else begin
      time_q <= nxt;
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/rtc_port.sv
module rtc_port
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  rtc_time_t         time_i,
  input  logic              uip_i,
  output logic              halt_o,
  output logic              twr_o,
  output rtc_field_e        tfield_o,
  output logic [6:0]        tval_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;
  localparam int unsigned RAM_N = DEPTH - RAM_BASE;

  logic [7:0] alarm_q [3];
  logic [6:0] cfg_q;
  logic [7:0] mode_q;
  logic [7:0] ram_q [RAM_N];

  logic              bin, h24, is_ram;
  logic [ADDR_W-1:0] ram_idx;
  int                a;

  assign bin     = mode_q[2];
  assign h24     = mode_q[1];
  assign halt_o  = mode_q[7];
  assign a       = int'(addr_i);
  assign is_ram  = a >= RAM_BASE;
  assign ram_idx = addr_i - ADDR_W'(RAM_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) alarm_q[i] <= '0;
      for (int i = 0; i < int'(RAM_N); i++) ram_q[i] <= '0;
      cfg_q  <= '0;
      mode_q <= 8'h02;
    end else if (wr_en_i) begin
      case (a)
        A_ASEC: alarm_q[0] <= wdata_i;
        A_AMIN: alarm_q[1] <= wdata_i;
        A_AHR:  alarm_q[2] <= wdata_i;
        A_CFG:  cfg_q      <= wdata_i[6:0];
        A_MODE: mode_q     <= wdata_i;
        default: if (is_ram) ram_q[ram_idx] <= wdata_i;
      endcase
    end
  end

  // write path: port format -> binary
  logic [7:0] tin, hv, hw;
  always_comb begin
    tin = bin ? wdata_i : bcd_to_bin(wdata_i);
    hv  = bin ? {1'b0, wdata_i[6:0]} : bcd_to_bin({1'b0, wdata_i[6:0]});
    if (h24) hw = tin;
    else     hw = ((hv == 8'd12) ? 8'd0 : hv) + (wdata_i[7] ? 8'd12 : 8'd0);
    twr_o    = 1'b0;
    tfield_o = FLD_SEC;
    tval_o   = 7'(tin);
    case (a)
      A_SEC: begin twr_o = wr_en_i; tfield_o = FLD_SEC; end
      A_MIN: begin twr_o = wr_en_i; tfield_o = FLD_MIN; end
      A_HR:  begin twr_o = wr_en_i; tfield_o = FLD_HR; tval_o = 7'(hw); end
      A_DOW: begin twr_o = wr_en_i; tfield_o = FLD_DOW; end
      A_DOM: begin twr_o = wr_en_i; tfield_o = FLD_DOM; end
      A_MON: begin twr_o = wr_en_i; tfield_o = FLD_MON; end
      A_YR:  begin twr_o = wr_en_i; tfield_o = FLD_YR; end
      default: ;
    endcase
  end

  // read path: binary -> port format
  logic       pm;
  logic [4:0] hr12;
  logic [6:0] disp;
  logic [7:0] hr_enc, hr_rd;
  always_comb begin
    pm     = time_i.hr >= 5'd12;
    hr12   = pm ? time_i.hr - 5'd12 : time_i.hr;
    disp   = (hr12 == 5'd0) ? 7'd12 : {2'b0, hr12};
    hr_enc = fmt_out(disp, bin);
    hr_rd  = h24 ? fmt_out({2'b0, time_i.hr}, bin) : (hr_enc | (pm ? 8'h80 : 8'h00));
  end

  always_comb begin
    rdata_o = '0;
    case (a)
      A_SEC:  rdata_o = fmt_out({1'b0, time_i.sec}, bin);
      A_ASEC: rdata_o = alarm_q[0];
      A_MIN:  rdata_o = fmt_out({1'b0, time_i.min}, bin);
      A_AMIN: rdata_o = alarm_q[1];
      A_HR:   rdata_o = hr_rd;
      A_AHR:  rdata_o = alarm_q[2];
      A_DOW:  rdata_o = fmt_out({4'b0, time_i.dow}, bin);
      A_DOM:  rdata_o = fmt_out({2'b0, time_i.dom}, bin);
      A_MON:  rdata_o = fmt_out({3'b0, time_i.mon}, bin);
      A_YR:   rdata_o = fmt_out(time_i.yr, bin);
      A_CFG:  rdata_o = {uip_i, cfg_q};
      A_MODE: rdata_o = mode_q;
      A_FLAG: rdata_o = 8'h00;
      A_STAT: rdata_o = 8'h80;
      default: if (is_ram) rdata_o = ram_q[ram_idx];
    endcase
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_CYCLES = 400,
  parameter int unsigned UIP_CYCLES = 40,
  parameter int unsigned ADDR_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic       uip, step, halt, twr;
  rtc_field_e tfield;
  logic [6:0] tval;
  rtc_time_t  cur_time;

  rtc_tick #(.SEC_CYCLES(SEC_CYCLES), .UIP_CYCLES(UIP_CYCLES)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt), .uip_o(uip), .step_o(step)
  );

  rtc_count u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .wr_i(twr),
    .field_i(tfield), .wval_i(tval), .time_o(cur_time)
  );

  rtc_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .time_i(cur_time), .uip_i(uip),
    .halt_o(halt), .twr_o(twr), .tfield_o(tfield), .tval_o(tval)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_CYCLES = 400,
  parameter int unsigned UIP_CYCLES = 40,
  parameter int unsigned ADDR_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [7:0]        rdata_o,
  input logic              uip_i,
  input logic              halt_i,
  input rtc_time_t         time_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= 0;
    else if (uip_i) run_q <= run_q + 1;
    else            run_q <= 0;
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(uip_i) && !$past(wr_en_i) && $past(time_i.sec) < 6'd59)
      |-> time_i.sec == $past(time_i.sec) + 6'd1);

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(uip_i) && !$past(wr_en_i) && $past(time_i.sec) == 6'd59)
      |-> time_i.sec == 6'd0);

  p_uip_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(uip_i) && !halt_i) |-> run_q == UIP_CYCLES);

  p_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uip_i && !wr_en_i) |=> $stable(time_i));

  p_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !uip_i);

  p_stat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == A_STAT) |-> rdata_o == 8'h80);

  p_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == A_FLAG) |-> rdata_o == 8'h00);
endmodule

bind rtc_calendar rtc_calendar_chk #(
  .SEC_CYCLES(SEC_CYCLES), .UIP_CYCLES(UIP_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rdata_o(rdata_o), .uip_i(uip), .halt_i(halt), .time_i(cur_time)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int SEC = 400;
  localparam int UIP = 40;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  always #2 clk = ~clk;

  rtc_calendar #(.SEC_CYCLES(SEC), .UIP_CYCLES(UIP), .ADDR_W(AW)) u_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct { int s; int m; int h; int dw; int dm; int mo; int y; } tm_t;

  int n_chk = 0;
  int n_fail = 0;
  int ram_img [64];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    addr = AW'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(int a, output int d);
    @(negedge clk);
    wr = 1'b0; addr = AW'(a);
    #1 d = int'(rdata);
  endtask

  function automatic int enc(int v, bit b);
    return b ? v : ((v / 10) * 16 + v % 10);
  endfunction

  function automatic int enc_hr(int h, bit b, bit h24);
    int d;
    if (h24) return enc(h, b);
    d = h % 12;
    if (d == 0) d = 12;
    return (h >= 12 ? 128 : 0) + enc(d, b);
  endfunction

  function automatic int days(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t adv(tm_t t);
    tm_t n = t;
    n.s = t.s + 1;
    if (n.s == 60) begin
      n.s = 0; n.m = t.m + 1;
      if (n.m == 60) begin
        n.m = 0; n.h = t.h + 1;
        if (n.h == 24) begin
          n.h = 0;
          n.dw = (t.dw == 7) ? 1 : t.dw + 1;
          n.dm = t.dm + 1;
          if (n.dm > days(t.mo, t.y)) begin
            n.dm = 1; n.mo = t.mo + 1;
            if (n.mo == 13) begin n.mo = 1; n.y = (t.y + 1) % 100; end
          end
        end
      end
    end
    return n;
  endfunction

  task automatic load(tm_t t, bit b, bit h24);
    int mode = (b ? 4 : 0) + (h24 ? 2 : 0);
    wr_reg(11, 128 + mode);
    wr_reg(0, enc(t.s, b));
    wr_reg(2, enc(t.m, b));
    wr_reg(4, enc_hr(t.h, b, h24));
    wr_reg(6, enc(t.dw, b));
    wr_reg(7, enc(t.dm, b));
    wr_reg(8, enc(t.mo, b));
    wr_reg(9, enc(t.y, b));
    wr_reg(11, mode);
  endtask

  task automatic wait_update();
    int d, hi = 0, guard = 0;
    rd_reg(10, d);
    while ((d & 128) == 0 && guard < 2 * SEC) begin rd_reg(10, d); guard++; end
    while ((d & 128) != 0 && guard < 4 * SEC) begin hi++; rd_reg(10, d); guard++; end
    chk("R4", "busy window length", hi, UIP);
  endtask

  task automatic run_case(string tag, tm_t t, bit b, bit h24);
    tm_t e = adv(t);
    int d;
    load(t, b, h24);
    wait_update();
    rd_reg(0, d); chk(tag, "seconds", d, enc(e.s, b));
    rd_reg(2, d); chk(tag, "minutes", d, enc(e.m, b));
    rd_reg(4, d); chk(tag, "hours",   d, enc_hr(e.h, b, h24));
    rd_reg(6, d); chk(tag, "weekday", d, enc(e.dw, b));
    rd_reg(7, d); chk(tag, "day",     d, enc(e.dm, b));
    rd_reg(8, d); chk(tag, "month",   d, enc(e.mo, b));
    rd_reg(9, d); chk(tag, "year",    d, enc(e.y, b));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d, s0, hits;
    tm_t t;
    void'($urandom(32'd2024));
    #10 rst_n = 1'b1;

    // R10 reset state
    rd_reg(0, d);  chk("R10", "seconds", d, 0);
    rd_reg(4, d);  chk("R10", "hours", d, 0);
    rd_reg(6, d);  chk("R10", "weekday", d, 1);
    rd_reg(7, d);  chk("R10", "day", d, 1);
    rd_reg(8, d);  chk("R10", "month", d, 1);
    rd_reg(9, d);  chk("R10", "year", d, 0);
    rd_reg(10, d); chk("R10", "config", d, 0);
    rd_reg(11, d); chk("R10", "mode", d, 8'h02);
    rd_reg(14, d); chk("R10", "ram first", d, 0);
    rd_reg(63, d); chk("R10", "ram last", d, 0);

    // R5 freeze holds time and keeps busy low
    wr_reg(11, 8'h82);
    wr_reg(0, 8'h10);
    hits = 0;
    for (int i = 0; i < 2 * SEC; i++) begin
      rd_reg(10, d);
      if ((d & 128) != 0) hits++;
    end
    chk("R5", "busy while frozen", hits, 0);
    rd_reg(0, d); chk("R5", "seconds frozen", d, 8'h10);

    // R9 read-only registers and busy bit
    wr_reg(12, 8'hFF); rd_reg(12, d); chk("R9", "flags", d, 0);
    wr_reg(13, 8'h00); rd_reg(13, d); chk("R9", "status", d, 8'h80);
    wr_reg(10, 8'hFF); rd_reg(10, d); chk("R9", "config", d, 8'h7F);
    wr_reg(10, 8'h00);

    // R1 alarm and RAM storage
    wr_reg(1, 8'h11); wr_reg(3, 8'h22); wr_reg(5, 8'h33);
    rd_reg(1, d); chk("R1", "alarm sec", d, 8'h11);
    rd_reg(3, d); chk("R1", "alarm min", d, 8'h22);
    rd_reg(5, d); chk("R1", "alarm hr", d, 8'h33);
    rd_reg(0, d); chk("R1", "time untouched", d, 8'h10);
    for (int a = 14; a < 64; a++) begin
      ram_img[a] = int'($urandom % 256);
      wr_reg(a, ram_img[a]);
    end
    hits = 0;
    for (int a = 14; a < 64; a++) begin
      rd_reg(a, d);
      if (d != ram_img[a]) hits++;
    end
    chk("R1", "ram mismatches", hits, 0);

    // R6 R7 R8 format handling while frozen
    wr_reg(11, 8'h86);
    wr_reg(0, 8'h1E); wr_reg(4, 8'h0D);
    rd_reg(0, d); chk("R6", "binary seconds", d, 8'h1E);
    rd_reg(4, d); chk("R7", "binary 24h hour", d, 8'h0D);
    rd_reg(1, d); chk("R6", "alarm raw", d, 8'h11);
    wr_reg(11, 8'h80);
    rd_reg(0, d); chk("R8", "bcd seconds after switch", d, 8'h30);
    rd_reg(4, d); chk("R7", "12h pm hour", d, 8'h81);
    wr_reg(11, 8'h82);
    rd_reg(4, d); chk("R8", "24h hour after switch", d, 8'h13);
    wr_reg(11, 8'h80); wr_reg(4, 8'h12); wr_reg(11, 8'h82);
    rd_reg(4, d); chk("R7", "12 am is midnight", d, 8'h00);
    wr_reg(11, 8'h80); wr_reg(4, 8'h92); wr_reg(11, 8'h82);
    rd_reg(4, d); chk("R7", "12 pm is noon", d, 8'h12);

    // directed rollovers
    t = '{s: 59, m: 59, h: 23, dw: 7, dm: 31, mo: 12, y: 99}; run_case("R2", t, 1'b0, 1'b1);
    t = '{s: 59, m: 59, h: 23, dw: 3, dm: 28, mo: 2,  y: 4};  run_case("R3", t, 1'b1, 1'b1);
    t = '{s: 59, m: 59, h: 23, dw: 3, dm: 28, mo: 2,  y: 5};  run_case("R3", t, 1'b0, 1'b1);
    t = '{s: 59, m: 59, h: 23, dw: 5, dm: 29, mo: 2,  y: 0};  run_case("R3", t, 1'b0, 1'b0);
    t = '{s: 59, m: 59, h: 23, dw: 1, dm: 30, mo: 4,  y: 21}; run_case("R3", t, 1'b1, 1'b0);
    t = '{s: 59, m: 59, h: 11, dw: 2, dm: 10, mo: 6,  y: 30}; run_case("R7", t, 1'b0, 1'b0);
    t = '{s: 59, m: 59, h: 23, dw: 2, dm: 10, mo: 6,  y: 30}; run_case("R7", t, 1'b1, 1'b0);

    // R4 time stable across the low window
    rd_reg(0, s0);
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      rd_reg(0, d);
      if (d != s0) hits++;
    end
    chk("R4", "changes while idle", hits, 0);

    // random starts across all four formats
    for (int k = 0; k < 24; k++) begin
      t.s  = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
      t.m  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      t.h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      t.dw = 1 + int'($urandom % 7);
      t.mo = 1 + int'($urandom % 12);
      t.y  = int'($urandom % 100);
      t.dm = ($urandom % 2 == 0) ? days(t.mo, t.y) : 1 + int'($urandom % days(t.mo, t.y));
      run_case("R2", t, k[0], k[1]);
    end

    summary();
    $finish;
  end
endmodule